// File: doc/BRIEF.md
# Operate Microinstruction Unit

This block carries out the operate group of a 16-bit accumulator machine. An operate word holds a handful of independent control bits that clear, complement or increment the accumulator, clear or complement the link bit, and merge the front-panel data switches into the accumulator. A single operate word may set several of these bits. The unit applies them in three fixed phases, so each combination has one defined result. For example, clear followed by complement leaves the accumulator all ones, and complement followed by increment negates it.

The surrounding processor presents the instruction word, the current accumulator, link and switch value, then pulses a start strobe. On the next clock edge the unit registers the new accumulator and link and pulses a completion flag. A combinational flag reports at all times whether the presented word belongs to the operate group. The all-zero word is the halt instruction. It sets a sticky halt output, and while that output is set the unit refuses further work. Only reset or a restart pulse clears it.

Top module: `opr_micro_unit`

## Requirements
- R1: `is_operate` is high exactly when the instruction word ANDed with octal 077700 (bits 6 to 14) is zero. The result is combinational.
- R2: Phase one runs first. Bit 0 clears the accumulator and bit 3 clears the link.
- R3: Phase two works on the result of phase one. Bit 1 inverts all 16 accumulator bits and bit 4 inverts the link. Word octal 100003 yields 0xFFFF.
- R4: Phase three works on the result of phase two. Bit 2 adds one to the accumulator, and a carry out of bit 15 inverts the link. Word octal 100006 yields the two's complement negation.
- R5: Bit 5 ORs the switch value into the accumulator in phase three, after the increment.
- R6: An accepted all-zero word sets `halted` at the next edge and leaves the accumulator and link outputs equal to their inputs.
- R7: A word with only bit 15 set is a no-op: the outputs take the input accumulator and link unchanged.
- R8: `halted` holds until reset or `restart`. While it is high, `start` is ignored, and `restart` takes priority over `start` in the same cycle.
- R9: A start with a non-operate word leaves `acc_out`, `link_out` and `halted` unchanged and raises no `done`.
- R10: `done` is high for exactly the one cycle after an accepted start. An accepted start is a start with an operate word while not halted and without restart.
- R11: After reset, `acc_out`, `link_out`, `halted` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Execute the presented word at this edge |
| restart | input | 1 | Clears the halt state |
| instr | input | 16 | Instruction word |
| acc_in | input | 16 | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | 16 | Data switch value |
| is_operate | output | 1 | Word belongs to the operate group |
| acc_out | output | 16 | Registered new accumulator |
| link_out | output | 1 | Registered new link |
| halted | output | 1 | Sticky halt indication |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the phase-order corner cases. Word 100003 exposes a design that complements before clearing, because that design returns zero instead of all ones. Increment with OR on accumulator 0x00FF and switches 0x0100 returns 0x0200 if the OR is applied first, where the correct result is 0x0100. Increment of 0xFFFF catches a missing link toggle on carry. It also checks that the halt word is told apart from the bit-15 no-op, that starts are dropped while halted, and that words with any bit from 6 to 14 set are excluded from the group. A design that widened the group mask would run those excluded words as operates.

// File: rtl/opr_pkg.sv
package opr_pkg;

   // Decoded control bundle shared by the decoder and the phase stages
   typedef struct packed {
      logic member;     // word lies in the operate group
      logic halt_code;  // operate word with nothing set and bit 15 clear
      logic clr_acc;    // phase one
      logic clr_lnk;
      logic inv_acc;    // phase two
      logic inv_lnk;
      logic bump;       // phase three
      logic merge_sw;
   } opr_ctl_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
   import opr_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter logic [15:0] GROUP_MASK = 16'o077700,
   parameter int          B_CLR_ACC  = 0,
   parameter int          B_INV_ACC  = 1,
   parameter int          B_BUMP     = 2,
   parameter int          B_CLR_LNK  = 3,
   parameter int          B_INV_LNK  = 4,
   parameter int          B_MERGE    = 5
) (
   input  logic [DATA_W-1:0] word,
   output opr_ctl_t          ctl
);
   localparam int TOP_BIT = DATA_W - 1;
   localparam logic [DATA_W-1:0] MASK_W = DATA_W'(GROUP_MASK);
   localparam logic [DATA_W-1:0] OP_BITS =
      (DATA_W'(1) << B_CLR_ACC) | (DATA_W'(1) << B_INV_ACC) |
      (DATA_W'(1) << B_BUMP)    | (DATA_W'(1) << B_CLR_LNK) |
      (DATA_W'(1) << B_INV_LNK) | (DATA_W'(1) << B_MERGE);

   // elaboration-time parameter checks
   if (DATA_W < 8 || DATA_W > 16) begin : g_bad_width
      $error("opr_decode: DATA_W out of supported range");
   end
   if ($countones(OP_BITS) != 6) begin : g_bad_bits
      $error("opr_decode: control bit positions overlap");
   end
   if ((OP_BITS & MASK_W) != '0) begin : g_bad_mask
      $error("opr_decode: control bits fall inside the group mask");
   end

   logic in_group;
   logic any_op;

   always_comb begin
      in_group      = (word & MASK_W) == '0;
      any_op        = (word & OP_BITS) != '0;
      ctl.member    = in_group;
      ctl.halt_code = in_group && !any_op && !word[TOP_BIT];
      ctl.clr_acc   = in_group && word[B_CLR_ACC];
      ctl.clr_lnk   = in_group && word[B_CLR_LNK];
      ctl.inv_acc   = in_group && word[B_INV_ACC];
      ctl.inv_lnk   = in_group && word[B_INV_LNK];
      ctl.bump      = in_group && word[B_BUMP];
      ctl.merge_sw  = in_group && word[B_MERGE];
   end
endmodule

// File: rtl/opr_clear_stage.sv
module opr_clear_stage #(
   parameter int DATA_W = 16
) (
   input  logic              clr_acc,
   input  logic              clr_lnk,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              lnk_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              lnk_o
);
   always_comb begin
      acc_o = clr_acc ? '0 : acc_i;
      lnk_o = clr_lnk ? 1'b0 : lnk_i;
   end
endmodule

// File: rtl/opr_invert_stage.sv
module opr_invert_stage #(
   parameter int DATA_W = 16
) (
   input  logic              inv_acc,
   input  logic              inv_lnk,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              lnk_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              lnk_o
);
   always_comb begin
      acc_o = inv_acc ? ~acc_i : acc_i;
      lnk_o = lnk_i ^ inv_lnk;
   end
endmodule

// File: rtl/opr_bump_stage.sv
module opr_bump_stage #(
   parameter int DATA_W    = 16,
   parameter bit BUMP_FIRST = 1'b1
) (
   input  logic              bump,
   input  logic              merge_sw,
   input  logic [DATA_W-1:0] sw,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              lnk_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              lnk_o
);
   logic [DATA_W:0] sum;

   if (BUMP_FIRST) begin : g_bump_then_or
      always_comb begin
         sum   = {1'b0, acc_i} + {{DATA_W{1'b0}}, bump};
         acc_o = sum[DATA_W-1:0] | (merge_sw ? sw : '0);
         lnk_o = lnk_i ^ sum[DATA_W];
      end
   end else begin : g_or_then_bump
      always_comb begin
         sum   = {1'b0, acc_i | (merge_sw ? sw : '0)} + {{DATA_W{1'b0}}, bump};
         acc_o = sum[DATA_W-1:0];
         lnk_o = lnk_i ^ sum[DATA_W];
      end
   end
endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit
   import opr_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit BUMP_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              restart,
   input  logic [DATA_W-1:0] instr,
   input  logic [DATA_W-1:0] acc_in,
   input  logic              link_in,
   input  logic [DATA_W-1:0] switches,
   output logic              is_operate,
   output logic [DATA_W-1:0] acc_out,
   output logic              link_out,
   output logic              halted,
   output logic              done
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   opr_ctl_t          ctl;
   logic [DATA_W-1:0] acc_p1, acc_p2, acc_p3;
   logic              lnk_p1, lnk_p2, lnk_p3;
   logic              accept;

   opr_decode #(.DATA_W(DATA_W)) u_dec (
      .word (instr),
      .ctl  (ctl)
   );

   opr_clear_stage #(.DATA_W(DATA_W)) u_ph1 (
      .clr_acc (ctl.clr_acc),
      .clr_lnk (ctl.clr_lnk),
      .acc_i   (acc_in),
      .lnk_i   (link_in),
      .acc_o   (acc_p1),
      .lnk_o   (lnk_p1)
   );

   opr_invert_stage #(.DATA_W(DATA_W)) u_ph2 (
      .inv_acc (ctl.inv_acc),
      .inv_lnk (ctl.inv_lnk),
      .acc_i   (acc_p1),
      .lnk_i   (lnk_p1),
      .acc_o   (acc_p2),
      .lnk_o   (lnk_p2)
   );

   opr_bump_stage #(.DATA_W(DATA_W), .BUMP_FIRST(BUMP_FIRST)) u_ph3 (
      .bump     (ctl.bump),
      .merge_sw (ctl.merge_sw),
      .sw       (switches),
      .acc_i    (acc_p2),
      .lnk_i    (lnk_p2),
      .acc_o    (acc_p3),
      .lnk_o    (lnk_p3)
   );

   assign is_operate = ctl.member;
   assign accept     = start && !restart && !halted && ctl.member;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_out  <= '0;
         link_out <= 1'b0;
         halted   <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= accept;
         if (restart) begin
            halted <= 1'b0;
         end else if (accept) begin
            acc_out  <= acc_p3;
            link_out <= lnk_p3;
            if (ctl.halt_code) halted <= 1'b1;
         end
      end
   end

   // R9: no accepted start means the registered results stay put
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(start && !restart && !halted && is_operate) |=> $stable(acc_out) && $stable(link_out));

   // R10: completion follows an operate start by one cycle
   p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start && is_operate && !restart));

   // R8: halt is sticky without restart
   p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !restart |=> halted);

   // R6: halt word sets the halt state and passes the accumulator through
   p_halt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start && !restart && !halted && instr == '0 |=> halted && acc_out == $past(acc_in));

   // R3: clear then invert gives all ones
   p_set_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start && !restart && !halted && instr == DATA_W'(16'o100003) |=> acc_out == ALL_ONES);

   // R4: increment of all ones wraps and flips the link
   p_carry_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start && !restart && !halted && instr == DATA_W'(16'o100004) && acc_in == ALL_ONES
      |=> acc_out == '0 && link_out == !$past(link_in));

   // R8: restart always releases the halt
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !halted);
endmodule

// File: tb/tb_opr_micro_unit.sv
module tb_opr_micro_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, restart, link_in;
   logic [15:0] instr, acc_in, switches;
   logic        is_operate, link_out, halted, done;
   logic [15:0] acc_out;

   int n_checks = 0;
   int n_fail   = 0;

   logic [15:0] e_acc;
   logic        e_lnk, e_halt;

   always #2 clk = ~clk;

   opr_micro_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
      .instr(instr), .acc_in(acc_in), .link_in(link_in), .switches(switches),
      .is_operate(is_operate), .acc_out(acc_out), .link_out(link_out),
      .halted(halted), .done(done)
   );

   function automatic logic [16:0] model(input logic [15:0] w, input logic [15:0] a,
                                         input logic l, input logic [15:0] s);
      logic [16:0] sum;
      if (w[0]) a = 16'h0;
      if (w[3]) l = 1'b0;
      if (w[1]) a = ~a;
      if (w[4]) l = ~l;
      if (w[2]) begin
         sum = {1'b0, a} + 17'd1;
         a   = sum[15:0];
         if (sum[16]) l = ~l;
      end
      if (w[5]) a = a | s;
      return {l, a};
   endfunction

   function automatic logic in_group(input logic [15:0] w);
      return (w & 16'o077700) == 16'h0;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [15:0] w, input logic [15:0] a,
                         input logic l, input logic [15:0] s, input logic rs);
      logic [16:0] r;
      logic        acc_ok;
      @(negedge clk);
      instr = w; acc_in = a; link_in = l; switches = s; start = 1'b1; restart = rs;
      #1;
      chk({tag, " R1 group flag"}, {15'h0, is_operate}, {15'h0, in_group(w)});
      acc_ok = in_group(w) && !e_halt && !rs;
      if (rs) e_halt = 1'b0;
      if (acc_ok) begin
         r = model(w, a, l, s);
         e_acc = r[15:0]; e_lnk = r[16];
         if (w == 16'h0) e_halt = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; restart = 1'b0;
      chk({tag, " acc"}, acc_out, e_acc);
      chk({tag, " link"}, {15'h0, link_out}, {15'h0, e_lnk});
      chk({tag, " halted"}, {15'h0, halted}, {15'h0, e_halt});
      chk({tag, " R10 done"}, {15'h0, done}, {15'h0, acc_ok});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd1234);
      rst_n = 1'b0; start = 1'b0; restart = 1'b0; link_in = 1'b0;
      instr = 16'h0; acc_in = 16'h0; switches = 16'h0;
      e_acc = 16'h0; e_lnk = 1'b0; e_halt = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 acc", acc_out, 16'h0);
      chk("R11 link", {15'h0, link_out}, 16'h0);
      chk("R11 halted", {15'h0, halted}, 16'h0);
      chk("R11 done", {15'h0, done}, 16'h0);
      rst_n = 1'b1;

      run_op("R2 clear ac+link", 16'o100011, 16'h1234, 1'b1, 16'h0, 1'b0);
      chk("R2 zero", acc_out, 16'h0);
      run_op("R3 set all", 16'o100003, 16'h5A5A, 1'b0, 16'h0, 1'b0);
      chk("R3 ones", acc_out, 16'hFFFF);
      run_op("R3 link inv", 16'o100030, 16'h0, 1'b1, 16'h0, 1'b0);
      chk("R3 link one", {15'h0, link_out}, 16'h1);
      run_op("R4 negate", 16'o100006, 16'h0005, 1'b0, 16'h0, 1'b0);
      chk("R4 neg five", acc_out, 16'hFFFB);
      run_op("R4 negate zero", 16'o100006, 16'h0000, 1'b0, 16'h0, 1'b0);
      chk("R4 carry link", {15'h0, link_out}, 16'h1);
      run_op("R4 wrap", 16'o100004, 16'hFFFF, 1'b1, 16'h0, 1'b0);
      chk("R4 wrap link", {15'h0, link_out}, 16'h0);
      run_op("R5 inc then or", 16'o100044, 16'h00FF, 1'b0, 16'h0100, 1'b0);
      chk("R5 order", acc_out, 16'h0100);
      run_op("R7 noop", 16'o100000, 16'hBEEF, 1'b1, 16'hFFFF, 1'b0);
      chk("R7 pass", acc_out, 16'hBEEF);
      run_op("R9 non-op", 16'o104076, 16'h1111, 1'b0, 16'h0, 1'b0);
      run_op("R9 bit7", 16'o100200, 16'h2222, 1'b0, 16'h0, 1'b0);
      run_op("R6 halt", 16'o000000, 16'h3C3C, 1'b1, 16'h0, 1'b0);
      chk("R6 halt pass", acc_out, 16'h3C3C);
      run_op("R8 ignored", 16'o100001, 16'h7777, 1'b0, 16'h0, 1'b0);
      run_op("R8 restart wins", 16'o100001, 16'h7777, 1'b0, 16'h0, 1'b1);
      chk("R8 released", {15'h0, halted}, 16'h0);
      run_op("R8 after restart", 16'o100002, 16'h00F0, 1'b0, 16'h0, 1'b0);

      for (int i = 0; i < 300; i++) begin
         logic [15:0] w;
         w = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 9'h0, 6'($urandom)};
         if ($urandom_range(7, 0) == 0) w = 16'($urandom);
         if (w == 16'h0) w = 16'o100000;
         run_op("R2 R3 R4 R5 random", w, 16'($urandom), 1'($urandom), 16'($urandom), 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule